// File: doc/BRIEF.md
# Pseudo-Random Obstacle Spawner

This block decides, once per game tick, whether a new obstacle enters the playfield and, if it does, which of four lanes receives it. Two free-running linear feedback shift registers drive the decision. A 32-bit register supplies a single spawn decision bit. A separate 16-bit register picks the destination lane. Both registers step only on cycles where the game tick enable is high.

The result is a registered, one-hot lane strobe vector with at most one bit set. It feeds the per-lane obstacle shift registers. A synchronous reset or the player's dead flag reloads both registers with fixed nonzero seeds and silences the strobes. Because the seeds are never zero, the sequences cannot lock up.

Top module: `obstacle_spawner`

## Requirements
- R1: The spawn register `s` is 32 bits wide. On each advancing cycle it becomes `{s[30:0], s[31]^s[21]^s[1]^s[0]}`. It never holds zero.
- R2: The lane register `l` is 16 bits wide. On each advancing cycle it becomes `{l[14:0], l[15]^l[13]^l[12]^l[10]}`. Over a long run, every lane index 0..3 is selected.
- R3: Both registers advance only on cycles where `tick` is high and neither `rst` nor `dead` is high. In all other cycles they hold their value.
- R4: Suppose `tick` is high in a cycle and `s[31]` (the value before the advance) is 1. In the next cycle, `lane_strobe` has exactly bit `l[15:14]` set, where bit k means lane k. If `s[31]` is 0, `lane_strobe` is all zero in the next cycle.
- R5: At most one bit of `lane_strobe` is ever high.
- R6: `rst` and `dead` are synchronous and active high. Either one loads `s` with 32'h1357_9BDF and `l` with 16'hACE1, and zeroes `lane_strobe` in the next cycle. Both override `tick`.
- R7: In every cycle that follows a cycle with `tick` low, `lane_strobe` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Game tick enable, one cycle per game update |
| dead | input | 1 | Player-dead flag, reseeds and silences the spawner |
| lane_strobe | output | 4 | Registered one-hot obstacle strobe, bit k for lane k |

## Verification
The spawner is first driven with a tick on every cycle. This exposes any error in the feedback taps or the lane bit choice within a few dozen spawns. It is then driven with a tick on only every third cycle. A register that stepped without a tick would shift the whole expected sequence, so this pattern separates correct gating from free stepping. A dead pulse arrives together with a tick in the middle of a run, which shows whether the reseed wins over the advance. Idle stretches and a count of lanes hit confirm that strobes stay quiet without a tick and that all four lanes are reachable.

// File: rtl/spawn_pkg.sv
package spawn_pkg;
  localparam int unsigned SPAWN_W_DEF = 32;
  localparam int unsigned LANE_W_DEF  = 16;
  localparam int unsigned LANES_DEF   = 4;
  // Tap masks: bit k set means state[k] joins the feedback XOR.
  localparam logic [SPAWN_W_DEF-1:0] SPAWN_TAPS_DEF = 32'h8020_0003;
  localparam logic [LANE_W_DEF-1:0]  LANE_TAPS_DEF  = 16'hB400;
  localparam logic [SPAWN_W_DEF-1:0] SPAWN_SEED_DEF = 32'h1357_9BDF;
  localparam logic [LANE_W_DEF-1:0]  LANE_SEED_DEF  = 16'hACE1;
endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int unsigned     WIDTH    = 16,
  parameter logic [WIDTH-1:0] TAP_MASK = '1,
  parameter logic [WIDTH-1:0] SEED     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             adv,
  output logic [WIDTH-1:0] state
);
  logic             fb;
  logic [WIDTH-1:0] state_nxt;

  always_comb begin
    fb        = ^(state & TAP_MASK);
    state_nxt = {state[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) state <= SEED;
    else if (adv)     state <= state_nxt;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0);  // R1
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clear) |=> $stable(state));  // R3
  AST_LFSR_RESEED: assert property (@(posedge clk) disable iff (rst)
    clear |=> (state == SEED));  // R6
endmodule

// File: rtl/lane_decoder.sv
module lane_decoder #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                 en,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_LANES-1:0] onehot
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign onehot[g] = en && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/obstacle_spawner.sv
module obstacle_spawner
  import spawn_pkg::*;
#(
  parameter int unsigned           NUM_LANES  = LANES_DEF,
  parameter int unsigned           SPAWN_W    = SPAWN_W_DEF,
  parameter int unsigned           LANE_W     = LANE_W_DEF,
  parameter logic [SPAWN_W-1:0]    SPAWN_TAPS = SPAWN_TAPS_DEF,
  parameter logic [LANE_W-1:0]     LANE_TAPS  = LANE_TAPS_DEF,
  parameter logic [SPAWN_W-1:0]    SPAWN_SEED = SPAWN_SEED_DEF,
  parameter logic [LANE_W-1:0]     LANE_SEED  = LANE_SEED_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 dead,
  output logic [NUM_LANES-1:0] lane_strobe
);
  localparam int unsigned IDX_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int unsigned SPAWN_BIT = SPAWN_W - 1;

  logic [SPAWN_W-1:0]   spawn_state;
  logic [LANE_W-1:0]    lane_state;
  logic [IDX_W-1:0]     lane_idx;
  logic                 spawn_now;
  logic                 step;
  logic [NUM_LANES-1:0] lane_sel;

  assign step      = tick && !dead;
  assign spawn_now = step && spawn_state[SPAWN_BIT];
  assign lane_idx  = lane_state[LANE_W-1 -: IDX_W];

  lfsr_core #(.WIDTH(SPAWN_W), .TAP_MASK(SPAWN_TAPS), .SEED(SPAWN_SEED)) u_spawn (
    .clk(clk), .rst(rst), .clear(dead), .adv(step), .state(spawn_state)
  );

  lfsr_core #(.WIDTH(LANE_W), .TAP_MASK(LANE_TAPS), .SEED(LANE_SEED)) u_lane (
    .clk(clk), .rst(rst), .clear(dead), .adv(step), .state(lane_state)
  );

  lane_decoder #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_dec (
    .en(spawn_now), .idx(lane_idx), .onehot(lane_sel)
  );

  always_ff @(posedge clk) begin
    if (rst || dead) lane_strobe <= '0;
    else             lane_strobe <= lane_sel;
  end

  AST_STROBE_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_strobe));  // R5
  AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (lane_strobe == '0));  // R7
  AST_DEAD_SILENCES: assert property (@(posedge clk) disable iff (rst)
    dead |=> (lane_strobe == '0));  // R6
  AST_SPAWN_GATED: assert property (@(posedge clk) disable iff (rst)
    (tick && !dead && !spawn_state[SPAWN_BIT]) |=> (lane_strobe == '0));  // R4
  AST_SPAWN_FIRES: assert property (@(posedge clk) disable iff (rst)
    (tick && !dead && spawn_state[SPAWN_BIT]) |=> $onehot(lane_strobe));  // R4
endmodule

// File: tb/tb_obstacle_spawner.sv
module tb_obstacle_spawner;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       dead = 1'b0;
  logic [3:0] lane_strobe;

  obstacle_spawner dut (
    .clk(clk), .rst(rst), .tick(tick), .dead(dead), .lane_strobe(lane_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int lane_hits[4] = '{0, 0, 0, 0};
  bit done = 1'b0;

  logic [31:0] ms = 32'h1357_9BDF;
  logic [15:0] ml = 16'hACE1;

  // Driver: applies inputs at the falling edge and queues the strobe expected after the next rising edge.
  task automatic step(input logic r, input logic t, input logic d, input string tg);
    item_t it;
    @(negedge clk);
    rst = r; tick = t; dead = d;
    it.tag = tg;
    if (r || d) begin
      it.exp = 4'b0000;
      ms = 32'h1357_9BDF;
      ml = 16'hACE1;
    end else if (t) begin
      it.exp = ms[31] ? (4'b0001 << ml[15:14]) : 4'b0000;
      ms = {ms[30:0], ms[31] ^ ms[21] ^ ms[1] ^ ms[0]};
      ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
    end else begin
      it.exp = 4'b0000;
    end
    q.push_back(it);
  endtask

  // Monitor: compares each result just after the edge that produces it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (lane_strobe !== it.exp) begin
          fails++;
          $display("FAIL %s: lane_strobe actual %b expected %b", it.tag, lane_strobe, it.exp);
        end
        checks++;
        if ($countones(lane_strobe) > 1) begin
          fails++;
          $display("FAIL R5: lane_strobe actual %b expected at most one bit", lane_strobe);
        end
        for (int k = 0; k < 4; k++) if (lane_strobe[k] === 1'b1) lane_hits[k]++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R6 reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R6 reset");
    // R1 R4: tick every cycle
    for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b0, "R1/R4 dense ticks");
    // R3 R7: tick every third cycle
    for (int i = 0; i < 300; i++) step(1'b0, (i % 3) == 0, 1'b0, "R3/R7 sparse ticks");
    // R6: dead together with tick overrides the advance
    step(1'b0, 1'b1, 1'b1, "R6 dead with tick");
    step(1'b0, 1'b1, 1'b1, "R6 dead held");
    for (int i = 0; i < 150; i++) step(1'b0, 1'b1, 1'b0, "R6 restart after dead");
    // R7: idle stretch
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, "R7 idle");
    // R6: reset mid-run, then R4 ticks resume from seed
    step(1'b1, 1'b1, 1'b0, "R6 reset with tick");
    for (int i = 0; i < 100; i++) step(1'b0, (i % 2) == 0, 1'b0, "R4 alternate ticks");
    step(1'b0, 1'b0, 1'b0, "R7 drain");
    @(posedge clk);
    #2;
    // R2: every lane index reached
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (lane_hits[k] == 0) begin
        fails++;
        $display("FAIL R2: lane %0d hits actual %0d expected >0", k, lane_hits[k]);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule